// File: doc/BRIEF.md
# S/PDIF Subframe Framer and Sample Extractor

The block takes the pulse-width classes produced by an edge detector running on a biphase-mark line and rebuilds subframes from them. A state machine looks for the flag, a pulse of one and a half bit cells that legal data never contains. It reads the three pulses after the flag to tell a left, right or block-start subframe apart, and then lets a slot counter and a shift register take the 28 data slots. When a subframe completes with good parity, the block presents the top 16 of the 24 audio bits together with a channel flag, a block-start flag and a one-cycle valid strobe.

When a left or block-start flag is recognised, the block also emits a one-cycle frame-sync pulse at its trailing edge. That pulse repeats once per sample period, so it can serve as the reference for an external clock multiplier. Every flag restarts the framing. A lost or corrupted pulse therefore costs at most the subframe it falls in.

Top module: `spdif_sf_framer`

## Requirements
- R1: While rst_ni is low and after its release, sample_o, chan_o, block_o, sample_vld_o and frame_sync_o are all 0.
- R2: A pulse counts only in a cycle with pulse_vld_i high. pulse_len_i gives its length in half-cells: 1 = one, 2 = two, 3 = three (the flag), 0 = out of range. In the data slots a two-half-cell pulse decodes as bit 0 and two consecutive one-half-cell pulses decode as bit 1.
- R3: After a flag, the next three pulses select the subframe kind. 3,1,1 gives left (chan_o = 0, block_o = 0). 2,1,2 gives right (chan_o = 1, block_o = 0). 1,1,3 gives block start (chan_o = 0, block_o = 1).
- R4: frame_sync_o is high for exactly one cycle, in the cycle after the fourth preamble pulse is accepted, and only for left and block-start subframes.
- R5: The 28 slots after the preamble carry 24 audio bits, least significant first, then validity, user, channel-status and parity. sample_o takes audio bits 23 down to 8.
- R6: sample_vld_o is high for one cycle, in the cycle after the last pulse of slot 31 is accepted. sample_o, chan_o and block_o update in that same cycle.
- R7: If the XOR of slots 4 to 31 is 1, no strobe is raised and sample_o, chan_o and block_o keep their previous values.
- R8: A flag that arrives during the data slots drops the partial subframe and starts a new preamble.
- R9: An out-of-range pulse, or a one-half-cell pulse followed by a two-half-cell pulse in the data slots, drops the subframe. Everything up to the next flag is then ignored.
- R10: A preamble that matches none of the three patterns produces neither a frame-sync pulse nor a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_vld_i | input | 1 | A classified pulse is present this cycle |
| pulse_len_i | input | 2 | Pulse length class in half-cells (0 = out of range) |
| sample_o | output | 16 | Upper 16 audio bits of the last good subframe |
| chan_o | output | 1 | 1 = right channel, 0 = left |
| block_o | output | 1 | Last good subframe started a block |
| sample_vld_o | output | 1 | One-cycle strobe for a new sample |
| frame_sync_o | output | 1 | One-cycle pulse at the end of a left or block-start flag |

## Verification
Some properties can be checked on every cycle, and the assertions do that. Frame-sync is a single-cycle pulse that follows an accepted pulse and leaves the machine in the data phase. A half-decoded bit exists only in the data phase. The slot counter stays inside the subframe. A sample strobe can only follow the last slot and never coincides with frame-sync. The sample register holds steady between strobes. Whether the right bits reach sample_o, whether each preamble sets the correct kind, and whether parity errors, stray flags, bad pulses and wrong preambles drop exactly one subframe can only be shown by the bench. It sweeps walking-one and arithmetic sample patterns over all three kinds and then injects each fault.

// File: rtl/spdif_frm_pkg.sv
package spdif_frm_pkg;

  typedef enum logic [1:0] {
    PL_BAD   = 2'd0,
    PL_SHORT = 2'd1,
    PL_LONG  = 2'd2,
    PL_FLAG  = 2'd3
  } pulse_len_e;

  typedef enum logic [1:0] {
    SF_LEFT  = 2'd0,
    SF_RIGHT = 2'd1,
    SF_BLOCK = 2'd2
  } sf_kind_e;

  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_PRE1 = 3'd1,
    ST_PRE2 = 3'd2,
    ST_PRE3 = 3'd3,
    ST_DATA = 3'd4
  } frm_state_e;

endpackage

// File: rtl/spdif_flag_fsm.sv
module spdif_flag_fsm import spdif_frm_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_vld_i,
  input  pulse_len_e pulse_len_i,
  input  logic       sub_done_i,
  input  logic       bit_err_i,
  output logic       in_data_o,
  output logic       sync_o,
  output sf_kind_e   kind_o,
  output logic       frame_sync_o
);

  frm_state_e state_q, state_d;
  sf_kind_e   kind_q, kind_d;
  pulse_len_e last_len;
  logic       fsync_q;

  // fourth preamble pulse expected for the kind picked by the second one
  always_comb begin
    case (kind_q)
      SF_LEFT:  last_len = PL_SHORT;
      SF_RIGHT: last_len = PL_LONG;
      default:  last_len = PL_FLAG;
    endcase
  end

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    sync_o  = 1'b0;
    if (pulse_vld_i) begin
      case (state_q)
        ST_HUNT: begin
          if (pulse_len_i == PL_FLAG) state_d = ST_PRE1;
        end
        ST_PRE1: begin
          state_d = ST_PRE2;
          case (pulse_len_i)
            PL_SHORT: kind_d = SF_BLOCK;
            PL_LONG:  kind_d = SF_RIGHT;
            PL_FLAG:  kind_d = SF_LEFT;
            default:  state_d = ST_HUNT;
          endcase
        end
        ST_PRE2: begin
          if (pulse_len_i == PL_SHORT)     state_d = ST_PRE3;
          else if (pulse_len_i == PL_FLAG) state_d = ST_PRE1;
          else                             state_d = ST_HUNT;
        end
        ST_PRE3: begin
          if (pulse_len_i == last_len) begin
            state_d = ST_DATA;
            sync_o  = 1'b1;
          end else if (pulse_len_i == PL_FLAG) begin
            state_d = ST_PRE1;
          end else begin
            state_d = ST_HUNT;
          end
        end
        ST_DATA: begin
          if (pulse_len_i == PL_FLAG)      state_d = ST_PRE1;
          else if (bit_err_i || sub_done_i) state_d = ST_HUNT;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      kind_q  <= SF_LEFT;
      fsync_q <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      fsync_q <= sync_o && (kind_q != SF_RIGHT);
    end
  end

  assign in_data_o    = (state_q == ST_DATA);
  assign kind_o       = kind_q;
  assign frame_sync_o = fsync_q;

  AST_FSYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |=> !frame_sync_o); // R4
  AST_FSYNC_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |-> $past(pulse_vld_i)); // R4
  AST_FSYNC_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |-> in_data_o); // R4

endmodule

// File: rtl/spdif_bit_pair.sv
module spdif_bit_pair import spdif_frm_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_data_i,
  input  logic       pulse_vld_i,
  input  pulse_len_e pulse_len_i,
  output logic       bit_vld_o,
  output logic       bit_o,
  output logic       err_o
);

  logic half_q, half_d;

  always_comb begin
    bit_vld_o = 1'b0;
    bit_o     = 1'b0;
    err_o     = 1'b0;
    half_d    = half_q;
    if (!in_data_i) begin
      half_d = 1'b0;
    end else if (pulse_vld_i) begin
      case (pulse_len_i)
        PL_SHORT: begin
          if (half_q) begin
            bit_vld_o = 1'b1;
            bit_o     = 1'b1;
            half_d    = 1'b0;
          end else begin
            half_d = 1'b1;
          end
        end
        PL_LONG: begin
          half_d = 1'b0;
          if (half_q) err_o = 1'b1;
          else        bit_vld_o = 1'b1;
        end
        PL_FLAG: half_d = 1'b0;
        default: begin
          err_o  = 1'b1;
          half_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= half_d;
  end

  AST_HALF_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q |-> in_data_i); // R2

endmodule

// File: rtl/spdif_slot_track.sv
module spdif_slot_track import spdif_frm_pkg::*; #(
  parameter int N_SLOTS   = 32,
  parameter int PRE_SLOTS = 4,
  parameter int AUDIO_W   = 24,
  parameter int SAMPLE_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  sf_kind_e            kind_i,
  input  logic                bit_vld_i,
  input  logic                bit_i,
  output logic                sub_done_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                chan_o,
  output logic                block_o,
  output logic                sample_vld_o
);

  localparam int SLOT_W = $clog2(N_SLOTS);
  localparam logic [SLOT_W-1:0] FIRST_SLOT = SLOT_W'(PRE_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(N_SLOTS - 1);
  localparam logic [SLOT_W-1:0] LAST_AUD   = SLOT_W'(PRE_SLOTS + AUDIO_W - 1);

  logic [SLOT_W-1:0]   slot_q;
  logic [AUDIO_W-1:0]  shreg_q;
  logic                par_q;
  sf_kind_e            kind_q;
  logic [SAMPLE_W-1:0] pick;
  logic                in_audio, last, par_ok;

  assign in_audio   = (slot_q >= FIRST_SLOT) && (slot_q <= LAST_AUD);
  assign last       = bit_vld_i && (slot_q == LAST_SLOT);
  assign par_ok     = ~(par_q ^ bit_i);
  assign sub_done_o = last;

  generate
    if (SAMPLE_W == AUDIO_W) begin : g_full
      assign pick = shreg_q;
    end else begin : g_top
      assign pick = shreg_q[AUDIO_W-1 -: SAMPLE_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= FIRST_SLOT;
      shreg_q <= '0;
      par_q   <= 1'b0;
      kind_q  <= SF_LEFT;
    end else if (start_i) begin
      slot_q <= FIRST_SLOT;
      par_q  <= 1'b0;
      kind_q <= kind_i;
    end else if (bit_vld_i) begin
      slot_q <= last ? FIRST_SLOT : slot_q + 1'b1;
      par_q  <= par_q ^ bit_i;
      if (in_audio) shreg_q <= {bit_i, shreg_q[AUDIO_W-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o     <= '0;
      chan_o       <= 1'b0;
      block_o      <= 1'b0;
      sample_vld_o <= 1'b0;
    end else begin
      sample_vld_o <= last && par_ok;
      if (last && par_ok) begin
        sample_o <= pick;
        chan_o   <= (kind_q == SF_RIGHT);
        block_o  <= (kind_q == SF_BLOCK);
      end
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q >= FIRST_SLOT) && (slot_q <= LAST_SLOT)); // R5
  AST_VLD_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |-> $past(bit_vld_i && (slot_q == LAST_SLOT))); // R6
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_o |-> ($stable(sample_o) && $stable(chan_o) && $stable(block_o))); // R7

endmodule

// File: rtl/spdif_sf_framer.sv
module spdif_sf_framer import spdif_frm_pkg::*; #(
  parameter int N_SLOTS   = 32,
  parameter int PRE_SLOTS = 4,
  parameter int AUDIO_W   = 24,
  parameter int SAMPLE_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pulse_vld_i,
  input  logic [1:0]          pulse_len_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                chan_o,
  output logic                block_o,
  output logic                sample_vld_o,
  output logic                frame_sync_o
);

  pulse_len_e len;
  sf_kind_e   kind;
  logic       in_data, sync, sub_done, bit_vld, bit_val, bit_err;

  assign len = pulse_len_e'(pulse_len_i);

  spdif_flag_fsm u_flag_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_vld_i (pulse_vld_i),
    .pulse_len_i (len),
    .sub_done_i  (sub_done),
    .bit_err_i   (bit_err),
    .in_data_o   (in_data),
    .sync_o      (sync),
    .kind_o      (kind),
    .frame_sync_o(frame_sync_o)
  );

  spdif_bit_pair u_bit_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_data_i  (in_data),
    .pulse_vld_i(pulse_vld_i),
    .pulse_len_i(len),
    .bit_vld_o  (bit_vld),
    .bit_o      (bit_val),
    .err_o      (bit_err)
  );

  spdif_slot_track #(
    .N_SLOTS  (N_SLOTS),
    .PRE_SLOTS(PRE_SLOTS),
    .AUDIO_W  (AUDIO_W),
    .SAMPLE_W (SAMPLE_W)
  ) u_slot_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (sync),
    .kind_i      (kind),
    .bit_vld_i   (bit_vld),
    .bit_i       (bit_val),
    .sub_done_o  (sub_done),
    .sample_o    (sample_o),
    .chan_o      (chan_o),
    .block_o     (block_o),
    .sample_vld_o(sample_vld_o)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_vld_o && frame_sync_o)); // R6

endmodule

// File: tb/spdif_sf_framer_bench.sv
`timescale 1ns/1ps
module spdif_sf_framer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [1:0]  len = 2'd0;
  logic [15:0] sample_o;
  logic        chan_o, block_o, sample_vld_o, frame_sync_o;

  int compared = 0;
  int mismatched = 0;
  int vld_cnt = 0;
  int fs_cnt = 0;
  logic [15:0] cap_s = '0;
  logic        cap_c = 1'b0;
  logic        cap_b = 1'b0;

  always #10 clk = ~clk;

  spdif_sf_framer u_spdif_sf_framer (
    .clk_i(clk), .rst_ni(rst_n), .pulse_vld_i(vld), .pulse_len_i(len),
    .sample_o(sample_o), .chan_o(chan_o), .block_o(block_o),
    .sample_vld_o(sample_vld_o), .frame_sync_o(frame_sync_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_vld_o) begin
        vld_cnt++;
        cap_s = sample_o;
        cap_c = chan_o;
        cap_b = block_o;
      end
      if (frame_sync_o) fs_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic send_pulse(input int n);
    @(negedge clk);
    vld = 1'b1;
    len = n[1:0];
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic send_bit(input bit b);
    if (b) begin send_pulse(1); send_pulse(1); end
    else send_pulse(2);
  endtask

  // kind: 0 left, 1 right, 2 block start
  task automatic send_pre(input int kind);
    send_pulse(3);
    case (kind)
      0: begin send_pulse(3); send_pulse(1); send_pulse(1); end
      1: begin send_pulse(2); send_pulse(1); send_pulse(2); end
      default: begin send_pulse(1); send_pulse(1); send_pulse(3); end
    endcase
    chk(frame_sync_o == (kind != 1), "R4 frame_sync timing", int'(frame_sync_o), int'(kind != 1));
  endtask

  task automatic send_data(input logic [23:0] audio, input logic [2:0] vuc, input bit bad_par);
    logic p;
    p = ^{audio, vuc} ^ bad_par;
    for (int i = 0; i < 24; i++) send_bit(audio[i]);
    for (int i = 0; i < 3; i++) send_bit(vuc[i]);
    send_bit(p);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic good_subframe(input int kind, input logic [23:0] audio, input logic [2:0] vuc);
    int v0, f0;
    v0 = vld_cnt;
    f0 = fs_cnt;
    send_pre(kind);
    send_data(audio, vuc, 1'b0);
    chk(sample_vld_o == 1'b1, "R6 strobe timing", int'(sample_vld_o), 1);
    settle();
    chk(vld_cnt == v0 + 1, "R6 one strobe", vld_cnt - v0, 1);
    chk(cap_s == audio[23:8], "R2 R5 sample", int'(cap_s), int'(audio[23:8]));
    chk(cap_c == (kind == 1) && cap_b == (kind == 2), "R3 kind",
        int'({cap_b, cap_c}), int'({kind == 2, kind == 1}));
    chk(fs_cnt == f0 + int'(kind != 1), "R4 frame_sync count", fs_cnt - f0, int'(kind != 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int v0, f0;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk({sample_o, chan_o, block_o, sample_vld_o, frame_sync_o} == '0, "R1 in reset",
        int'(sample_o), 0);
    rst_n = 1'b1;
    settle();
    chk({sample_o, chan_o, block_o, sample_vld_o, frame_sync_o} == '0, "R1 after release",
        int'(sample_o), 0);

    // data with no flag must be ignored (R9 hunt)
    v0 = vld_cnt;
    send_data(24'hFFFFFF, 3'b000, 1'b0);
    settle();
    chk(vld_cnt == v0 && fs_cnt == 0, "R9 no flag ignored", vld_cnt - v0, 0);

    // walking ones over all kinds
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 24; i++)
        good_subframe(k, 24'(1) << i, 3'(i));
    // arithmetic sweep
    for (int i = 0; i < 150; i++)
      good_subframe(i % 3, 24'(i * 24'h9E37B5 + 24'h01234F), 3'(i));

    // R7 parity error
    good_subframe(2, 24'hA5C3F0, 3'b101);
    held = sample_o;
    v0 = vld_cnt;
    send_pre(1);
    send_data(24'h123456, 3'b010, 1'b1);
    settle();
    chk(vld_cnt == v0, "R7 no strobe on parity error", vld_cnt - v0, 0);
    chk(sample_o == held && chan_o == 1'b0 && block_o == 1'b1, "R7 outputs held",
        int'(sample_o), int'(held));

    // R8 flag in the middle of data
    v0 = vld_cnt;
    send_pre(0);
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    good_subframe(1, 24'h7E1D42, 3'b011);
    chk(vld_cnt == v0 + 1, "R8 partial dropped", vld_cnt - v0, 1);

    // R9 out-of-range pulse
    v0 = vld_cnt;
    send_pre(0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_pulse(0);
    send_data(24'h0F0F0F, 3'b000, 1'b0);
    settle();
    chk(vld_cnt == v0, "R9 bad code drops", vld_cnt - v0, 0);
    good_subframe(0, 24'h33CC99, 3'b100);

    // R9 short followed by long
    v0 = vld_cnt;
    send_pre(1);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    send_pulse(1);
    send_pulse(2);
    send_data(24'hF00F0F, 3'b001, 1'b0);
    settle();
    chk(vld_cnt == v0, "R9 short-long drops", vld_cnt - v0, 0);
    good_subframe(1, 24'h55AA11, 3'b000);

    // R10 wrong preambles
    v0 = vld_cnt;
    f0 = fs_cnt;
    send_pulse(3); send_pulse(2); send_pulse(2); send_pulse(1);
    send_data(24'h0000FF, 3'b000, 1'b0);
    send_pulse(3); send_pulse(3); send_pulse(1); send_pulse(2);
    send_data(24'hFF0000, 3'b111, 1'b0);
    settle();
    chk(vld_cnt == v0, "R10 no sample", vld_cnt - v0, 0);
    chk(fs_cnt == f0, "R10 no frame_sync", fs_cnt - f0, 0);
    good_subframe(2, 24'hFEDCBA, 3'b110);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule